// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one start strobe into the stream of column addresses that an SDRAM read or write burst visits. The caller presents a start column, a three-bit burst length code and an ordering bit. From the next clock on, the block emits one column address per cycle, together with a valid flag and a flag that marks the final beat. It is meant to sit beside a memory controller's command sequencer, which issues the column commands while the block supplies their addresses.

Finite bursts of 2, 4 or 8 beats stay inside the aligned block of columns that holds the start column. The visiting order is either a wrapping increment or an XOR pattern. In full-page mode the block walks the whole row, wrapping at the row end, until a stop input ends it. A new start strobe takes effect on any cycle and replaces a burst that is still running. An illegal length and order combination gives a single beat and a one-cycle error pulse.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, and until the first start strobe, `valid_o`, `last_o` and `err_o` are low.
- R2: Length codes 000, 001, 010 and 011 give bursts of exactly 1, 2, 4 and 8 beats. `last_o` is high only on the final beat, and `valid_o` is low on the cycle after the final beat unless a new start was sampled.
- R3: With `order_i` = 0 (wrapping increment), beat k of a finite burst of length L carries the start column's bits above log2(L) unchanged. Its low log2(L) bits equal (start offset + k) mod L.
- R4: With `order_i` = 1 (XOR order), beat k of a finite burst of length L keeps the start column's upper bits. Its low log2(L) bits equal the start offset XOR k; for example, start 5 with length 8 gives 5,4,7,6,1,0,3,2.
- R5: Length code 111 with `order_i` = 0 is a full-page burst. Beat k is (start column + k) mod 2^COL_W, `last_o` never rises, and the burst runs until it is stopped or restarted.
- R6: When `stop_i` is sampled high while `valid_o` is high and `start_i` is low, `valid_o` is low from the next cycle.
- R7: `start_i` is accepted on every cycle, including during a burst, and has priority over `stop_i`. The first beat of the new burst appears the next cycle.
- R8: Length codes 100, 101 and 110, and code 111 with `order_i` = 1, give a single beat at the start column with `last_o` high. `err_o` is high for exactly that one cycle.
- R9: The first beat carries the start column unchanged, on the cycle after the strobe is sampled. Later beats follow one per clock with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new burst this cycle |
| start_col_i | input | COL_W | Start column of the burst |
| len_code_i | input | 3 | Burst length code |
| order_i | input | 1 | 0 wrapping increment, 1 XOR order |
| stop_i | input | 1 | End the running burst |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | `col_o` holds a beat |
| last_o | output | 1 | Current beat is the final one of a finite burst |
| err_o | output | 1 | One-cycle pulse for an illegal length/order combination |

## Verification
Directed bursts start at odd offsets, such as 5 with length 8 and 3 with length 4, in both orders. Because the two orders visit different sequences from such offsets, a swapped or broken ordering shows up at once. A start column with nonzero upper bits tells wrapping inside the aligned block apart from carrying into the block address. A full-page burst started two columns before the row end checks the row wrap and the stop path. Random strobes, codes, orders and stops, many landing mid-burst, exercise restart priority and early termination against a cycle model of the requirements.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
   typedef enum logic [2:0] {
      LEN_1    = 3'b000,
      LEN_2    = 3'b001,
      LEN_4    = 3'b010,
      LEN_8    = 3'b011,
      LEN_PAGE = 3'b111
   } len_code_e;

   localparam logic ORDER_INC = 1'b0;
   localparam logic ORDER_XOR = 1'b1;
endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode
   import colgen_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic [2:0]       code_i,
   input  logic             order_i,
   output logic [COL_W-1:0] mask_o,
   output logic             page_o,
   output logic             bad_o
);
   always_comb begin
      mask_o = '0;
      page_o = 1'b0;
      bad_o  = 1'b0;
      case (len_code_e'(code_i))
         LEN_1: mask_o = '0;
         LEN_2: mask_o = COL_W'(1);
         LEN_4: mask_o = COL_W'(3);
         LEN_8: mask_o = COL_W'(7);
         LEN_PAGE: begin
            if (order_i == ORDER_INC) begin
               mask_o = '1;
               page_o = 1'b1;
            end else begin
               bad_o = 1'b1;
            end
         end
         default: bad_o = 1'b1;
      endcase
   end

   // R8: an illegal request always collapses to a single beat
   always_comb begin
      if (bad_o) begin
         a_bad_single_r8: assert (mask_o == '0 && !page_o);
      end
   end
endmodule

// File: rtl/colgen_beat_ctrl.sv
module colgen_beat_ctrl #(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic             order_i,
   input  logic             stop_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             page_i,
   input  logic             bad_i,
   output logic [COL_W-1:0] beat_o,
   output logic [COL_W-1:0] col_base_o,
   output logic [COL_W-1:0] mask_o,
   output logic             order_o,
   output logic             active_o,
   output logic             last_o,
   output logic             err_o
);
   logic page_q;

   assign last_o = active_o && !page_q && (beat_o == mask_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_o   <= 1'b0;
         beat_o     <= '0;
         col_base_o <= '0;
         mask_o     <= '0;
         order_o    <= 1'b0;
         page_q     <= 1'b0;
         err_o      <= 1'b0;
      end else begin
         err_o <= start_i && bad_i;
         if (start_i) begin
            active_o   <= 1'b1;
            beat_o     <= '0;
            col_base_o <= start_col_i;
            mask_o     <= mask_i;
            order_o    <= order_i;
            page_q     <= page_i;
         end else if (active_o) begin
            if (stop_i || last_o) begin
               active_o <= 1'b0;
            end else begin
               beat_o <= beat_o + 1'b1;
            end
         end
      end
   end

   // R9: beats advance one per clock with no gaps
   p_beat_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && !start_i && !stop_i && !last_o) |=> (active_o && beat_o == $past(beat_o) + 1'b1));

   // R6: a sampled stop ends the burst on the next cycle
   p_stop_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && stop_i && !start_i) |=> !active_o);

   // R2: nothing follows the final beat without a new start
   p_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start_i) |=> !active_o);

   // R8: the error flag is a single-cycle pulse
   p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !start_i) |=> !err_o);
endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map
   import colgen_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic [COL_W-1:0] col_base_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic             order_i,
   output logic [COL_W-1:0] col_o
);
   logic [COL_W-1:0] inc_off;
   logic [COL_W-1:0] xor_off;

   assign inc_off = col_base_i + beat_i;
   assign xor_off = col_base_i ^ beat_i;

   for (genvar b = 0; b < COL_W; b++) begin : g_bit
      assign col_o[b] = !mask_i[b]          ? col_base_i[b] :
                        (order_i == ORDER_XOR) ? xor_off[b] : inc_off[b];
   end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [2:0]       len_code_i,
   input  logic             order_i,
   input  logic             stop_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o,
   output logic             err_o
);
   localparam int MIN_COL_W = 3;

   if (COL_W < MIN_COL_W) begin : g_bad_width
      $error("COL_W must cover an 8-beat block");
   end

   logic [COL_W-1:0] dec_mask;
   logic             dec_page;
   logic             dec_bad;
   logic [COL_W-1:0] beat;
   logic [COL_W-1:0] col_base;
   logic [COL_W-1:0] mask_q;
   logic             order_q;

   colgen_len_decode #(.COL_W(COL_W)) u_dec (
      .code_i  (len_code_i),
      .order_i (order_i),
      .mask_o  (dec_mask),
      .page_o  (dec_page),
      .bad_o   (dec_bad)
   );

   colgen_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .start_col_i (start_col_i),
      .order_i     (order_i),
      .stop_i      (stop_i),
      .mask_i      (dec_mask),
      .page_i      (dec_page),
      .bad_i       (dec_bad),
      .beat_o      (beat),
      .col_base_o  (col_base),
      .mask_o      (mask_q),
      .order_o     (order_q),
      .active_o    (valid_o),
      .last_o      (last_o),
      .err_o       (err_o)
   );

   colgen_addr_map #(.COL_W(COL_W)) u_map (
      .col_base_i (col_base),
      .mask_i     (mask_q),
      .beat_i     (beat),
      .order_i    (order_q),
      .col_o      (col_o)
   );

   // R7, R9: the first beat is the start column, one cycle after the strobe
   p_first_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (valid_o && col_o == $past(start_col_i)));

   // R8: an error always comes with a lone, final beat
   p_err_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (valid_o && last_o));

   // R2: the last-beat flag only marks real beats
   p_last_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);
endmodule

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb_top;
   localparam int COL_W = 9;
   localparam int WATCHDOG_CYC = 100000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [COL_W-1:0] start_col_i = '0;
   logic [2:0]       len_code_i = '0;
   logic             order_i = 1'b0;
   logic             stop_i = 1'b0;
   logic [COL_W-1:0] col_o;
   logic             valid_o;
   logic             last_o;
   logic             err_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   sdram_burst_colgen #(.COL_W(COL_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
      .len_code_i(len_code_i), .order_i(order_i), .stop_i(stop_i),
      .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
   );

   // reference state built from the requirements
   bit               m_act;
   int               m_k;
   int               m_len;
   bit               m_page;
   bit               m_ord;
   bit               m_err;
   logic [COL_W-1:0] m_sc;
   string            m_vtag;

   function automatic logic [COL_W-1:0] exp_col(logic [COL_W-1:0] sc, int len, bit page,
                                                bit ord, int k);
      logic [COL_W-1:0] msk;
      logic [COL_W-1:0] kk;
      kk  = COL_W'(k);
      msk = page ? '1 : COL_W'(len - 1);
      if (ord) return (sc & ~msk) | ((sc ^ kk) & msk);
      return (sc & ~msk) | ((sc + kk) & msk);
   endfunction

   task automatic check(string tag, int act, int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
      end
   endtask

   task automatic model_edge();
      if (start_i) begin
         m_act = 1; m_k = 0; m_sc = start_col_i; m_ord = order_i; m_page = 0;
         m_err = 0; m_vtag = "R7";
         case (len_code_i)
            3'b000: m_len = 1;
            3'b001: m_len = 2;
            3'b010: m_len = 4;
            3'b011: m_len = 8;
            3'b111: if (!order_i) begin m_page = 1; m_len = 0; end
                    else begin m_len = 1; m_err = 1; end
            default: begin m_len = 1; m_err = 1; end
         endcase
      end else begin
         m_err = 0;
         if (m_act) begin
            if (stop_i) begin m_act = 0; m_vtag = "R6"; end
            else if (!m_page && m_k == m_len - 1) begin m_act = 0; m_vtag = "R2"; end
            else begin m_k++; m_vtag = "R9"; end
         end
      end
   endtask

   task automatic compare();
      check(m_vtag, valid_o, m_act);
      check(m_err ? "R8" : "R2", last_o, m_act && !m_page && (m_k == m_len - 1));
      check("R8", err_o, m_err);
      if (m_act)
         check(m_page ? "R5" : (m_ord ? "R4" : "R3"), col_o,
               exp_col(m_sc, m_len, m_page, m_ord, m_k));
   endtask

   task automatic step();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
      start_i = 0;
      stop_i  = 0;
   endtask

   task automatic launch(int col, int code, bit ord);
      start_i = 1; start_col_i = COL_W'(col); len_code_i = 3'(code); order_i = ord;
      step();
   endtask

   initial begin
      #(WATCHDOG_CYC * 20);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      m_act = 0; m_err = 0; m_k = 0; m_len = 1; m_page = 0; m_ord = 0; m_sc = '0;
      m_vtag = "R1";
      repeat (3) @(negedge clk);
      check("R1", valid_o, 0); check("R1", last_o, 0); check("R1", err_o, 0);
      rst_n = 1;
      repeat (2) step();
      check("R1", valid_o, 0);

      // R4: start 5, length 8, XOR order; R3: same in increment order
      launch(9'h0A5, 3, 1); repeat (9) step();
      launch(9'h0A5, 3, 0); repeat (9) step();
      // R3 / R4: length 4 from offset 3, length 2 from offset 1
      launch(9'h1F3, 2, 0); repeat (4) step();
      launch(9'h1F3, 2, 1); repeat (4) step();
      launch(9'h041, 1, 1); repeat (3) step();
      launch(9'h042, 0, 0); repeat (2) step();
      // R5: full page across the row end, then stop (R6)
      launch(510, 7, 0); repeat (5) step();
      stop_i = 1; step(); step();
      // R8: reserved codes and page with XOR order
      launch(9'h077, 4, 0); step();
      launch(9'h078, 7, 1); repeat (2) step();
      // R7: restart mid-burst, start beats stop
      launch(9'h010, 3, 0); step();
      start_i = 1; stop_i = 1; start_col_i = 9'h123; len_code_i = 3'd2; order_i = 1;
      step(); repeat (4) step();

      // random traffic
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(5) == 0) begin
            start_i = 1;
            start_col_i = COL_W'($urandom);
            len_code_i = ($urandom_range(7) == 0) ? 3'($urandom) : 3'($urandom_range(3));
            if ($urandom_range(9) == 0) len_code_i = 3'd7;
            order_i = 1'($urandom);
         end
         if ($urandom_range(15) == 0) stop_i = 1;
         step();
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule